// File: doc/BRIEF.md
# Paged Memory Write-and-Poll Sequencer

This block sits on the host side of a two-wire serial bus. It stores a buffer of bytes into a serial memory that is organised in pages. A start pulse gives it a target address, a byte count and the chip-select bits. It pulls the data bytes one at a time from a streaming source. It then drives a lower bus-master byte engine through a simple command/response handshake. The engine handles all bit-level clock and data timing. The sequencer only asks for a start condition, a stop condition, or one byte to send, and it reads back whether that byte was acknowledged.

The transfer is cut into bursts that never cross a page boundary. Each burst is written as a start, a write control byte, two address bytes, the data bytes and a stop. The memory programs its array after the stop and ignores its bus while it does so. The sequencer therefore polls it with start plus write control byte, repeating until it sees an acknowledge or until a programmable retry budget runs out. Once the poll is acknowledged, the next burst begins. It can either close the bus with a stop and open a fresh header, or reuse the acknowledged control byte and go straight on to the address bytes. Completion is reported as a one-cycle done pulse with a held error code.

Top module: `wpoll_seq`

## Requirements
- R1: After reset, busy, done, eng_cmd_valid and src_ready are low and err_code is 0.
- R2: A burst is sent to the engine as these commands, in this order:
  - START (op code 01);
  - SEND (op code 11) of the control byte, whose bits 7:4 are 1010, bits 3:1 are chip_sel and bit 0 is 0;
  - SEND of the address high byte, whose bit 7 is 0 and bits 6:0 are address bits 14:8;
  - SEND of the address low byte, carrying address bits 7:0;
  - one SEND per data byte, in source order;
  - STOP (op code 10).
- R3: No burst crosses a 64-byte page boundary. A burst ends at the page end or at the end of the data. The next burst's header carries the first address of the following page. The address wraps from 0x7FFF to 0x0000.
- R4: After each burst's STOP, the sequencer issues START followed by SEND of the control byte. While that control byte is not acknowledged, it repeats the START and control byte.
- R5: With chain_en low, an acknowledged poll is followed by STOP and then a full new header for the next burst. After the last burst's acknowledged poll, a STOP is sent and done pulses for one cycle with err_code 0.
- R6: With chain_en high, an acknowledged poll that is not the last is followed directly by the next burst's address high byte, with no STOP or START between them.
- R7: A burst's poll may be answered with NACK at most poll_limit times. On the (poll_limit+1)-th NACK, the sequencer issues STOP and then ends with done and err_code 2.
- R8: A NACK on a header control byte, an address byte or a data byte is followed at once by STOP. No further data is taken, and the transfer ends with done and err_code 1.
- R9: A start with xfer_len 0 issues no bus command, takes no source byte and ends with done and err_code 0.
- R10: src_ready is high only while the sequencer waits for a data byte. Each accepted byte is sent in the very next cycle as a SEND command, and the total number of bytes taken equals the number of data SENDs issued.
- R11: A start pulse while busy is high is ignored, as are changes to the configuration inputs; the running transfer continues unchanged.
- R12: eng_cmd_valid is a one-cycle pulse. No new command is issued until the engine has responded to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| start_addr | input | ADDR_W | First memory byte address |
| xfer_len | input | LEN_W | Number of bytes to store |
| chip_sel | input | 3 | Chip-select bits placed in the control byte |
| poll_limit | input | RETRY_W | NACKed polls tolerated per burst |
| chain_en | input | 1 | Reuse the acknowledged poll as the next header |
| src_data | input | 8 | Data byte from the source |
| src_valid | input | 1 | Source byte available |
| src_ready | output | 1 | Sequencer takes the source byte this cycle |
| eng_cmd_valid | output | 1 | One-cycle command pulse to the byte engine |
| eng_cmd_op | output | 2 | Command: 01 start, 10 stop, 11 send byte |
| eng_cmd_byte | output | 8 | Byte to send for a send command |
| eng_rsp_valid | input | 1 | Engine finished the outstanding command |
| eng_rsp_ack | input | 1 | Slave acknowledged the sent byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 none, 1 byte NACK, 2 poll limit reached; held until the next start |

## Verification
The bench builds the block with its defaults: a 15-bit address, 64-byte pages, 16-bit length and 8-bit retry field.

With 64-byte pages, transfers of one to a few hundred bytes produce single bursts, bursts that split at a page edge, and runs of three or more bursts. Because the address is only 15 bits, a short transfer that starts near 0x7FFF reaches the wrap to address zero.

Since poll_limit is a runtime input, small values make the poll timeout reachable in a handful of polls. The modelled engine can NACK any chosen header, address or data byte, which exercises the abort path at each position within a burst.

// File: rtl/wpoll_pkg.sv
// Package: shared encodings for the write-and-poll sequencer.
// Assumes: the byte engine decodes the op code values below.
package wpoll_pkg;

    // Commands to the bus byte engine
    typedef enum logic [1:0] {
        BUS_NONE  = 2'b00,
        BUS_START = 2'b01,
        BUS_STOP  = 2'b10,
        BUS_SEND  = 2'b11
    } bus_op_e;

    // Completion status
    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_NACK = 2'd1,
        ERR_POLL = 2'd2
    } err_e;

    // Sequencer states
    typedef enum logic [3:0] {
        S_IDLE,
        S_HSTART,
        S_HCTRL,
        S_HADDR_HI,
        S_HADDR_LO,
        S_FETCH,
        S_DATA,
        S_WSTOP,
        S_PSTART,
        S_PCTRL,
        S_PSTOP,
        S_ABORT,
        S_DONE
    } seq_state_e;

    // Upper nibble of the memory control byte
    localparam logic [3:0] CTRL_CODE = 4'b1010;

endpackage

// File: rtl/wpoll_burst_calc.sv
// Module: wpoll_burst_calc
// Computes the length of the next burst: the smaller of the remaining byte
// count and the room left in the current page.
// Assumes: PAGE_BYTES is a power of two and LEN_W > log2(PAGE_BYTES).
module wpoll_burst_calc #(
    parameter int ADDR_W     = 15,
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 64,
    localparam int PAGE_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LEN_W-1:0]  remaining,
    output logic [PAGE_W:0]   burst_len
);

    localparam logic [PAGE_W:0] PAGE_SZ = (PAGE_W + 1)'(PAGE_BYTES);

    logic [PAGE_W:0] offset;
    logic [PAGE_W:0] room;

    // Room left between the current address and the end of its page
    always_comb begin
        offset = {1'b0, cur_addr[PAGE_W-1:0]};
        room   = PAGE_SZ - offset;
        if (remaining < LEN_W'(room)) begin
            burst_len = remaining[PAGE_W:0];
        end else begin
            burst_len = room;
        end
    end

    // A non-empty transfer yields a non-empty burst that stays inside its page
    assert_burst_in_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (remaining != '0) |-> ((burst_len != '0) && ((offset + burst_len) <= PAGE_SZ)));

endmodule

// File: rtl/wpoll_poll_ctr.sv
// Module: wpoll_poll_ctr
// Counts NACKed acknowledge polls within one burst and flags when the next
// NACK would exceed the allowed budget.
// Assumes: limit is held constant while the counter is in use.
module wpoll_poll_ctr #(
    parameter int RETRY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               nack,
    input  logic [RETRY_W-1:0] limit,
    output logic               exhausted
);

    logic [RETRY_W-1:0] cnt;

    // NACK counter, cleared at each burst stop
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (nack && !exhausted) begin
            cnt <= cnt + RETRY_W'(1);
        end
    end

    // Budget reached once the count equals the limit
    assign exhausted = (cnt == limit);

    // The count never passes the budget
    assert_poll_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (nack && exhausted) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/wpoll_cmd_port.sv
// Module: wpoll_cmd_port
// Turns a state's request into a one-cycle command pulse to the byte engine
// and tracks the single outstanding command until the engine responds.
// Assumes: the engine responds no earlier than the cycle after the pulse.
module wpoll_cmd_port
    import wpoll_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue,
    input  bus_op_e    op_in,
    input  logic [7:0] byte_in,
    input  logic       rsp_valid,
    output logic       cmd_valid,
    output bus_op_e    cmd_op,
    output logic [7:0] cmd_byte,
    output logic       rsp_fire
);

    logic pend;

    // Outstanding-command flag: set by a pulse, cleared by the response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (cmd_valid) begin
            pend <= 1'b1;
        end else if (rsp_valid) begin
            pend <= 1'b0;
        end
    end

    // Pulse a command only when none is in flight
    assign cmd_valid = issue && !pend;
    assign cmd_op    = op_in;
    assign cmd_byte  = byte_in;
    assign rsp_fire  = rsp_valid && pend;

    // Commands are single-cycle pulses
    assert_cmd_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

endmodule

// File: rtl/wpoll_seq.sv
// Module: wpoll_seq (top)
// Stores a byte stream into a paged serial memory through a bus byte engine.
// Splits the stream into page-bounded write bursts and polls the memory for
// an acknowledge after each burst before continuing.
// Assumes: ADDR_W <= 15; the configuration is sampled on an accepted start.
module wpoll_seq
    import wpoll_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 64,
    parameter int RETRY_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [LEN_W-1:0]   xfer_len,
    input  logic [2:0]         chip_sel,
    input  logic [RETRY_W-1:0] poll_limit,
    input  logic               chain_en,
    input  logic [7:0]         src_data,
    input  logic               src_valid,
    output logic               src_ready,
    output logic               eng_cmd_valid,
    output logic [1:0]         eng_cmd_op,
    output logic [7:0]         eng_cmd_byte,
    input  logic               eng_rsp_valid,
    input  logic               eng_rsp_ack,
    output logic               busy,
    output logic               done,
    output logic [1:0]         err_code
);

    localparam int PAGE_W = $clog2(PAGE_BYTES);

    seq_state_e         state;
    err_e               err_q;
    logic [ADDR_W-1:0]  cur_addr;
    logic [LEN_W-1:0]   remaining;
    logic [PAGE_W:0]    burst_left;
    logic [PAGE_W:0]    burst_len;
    logic [7:0]         data_q;
    logic [2:0]         sel_q;
    logic [RETRY_W-1:0] limit_q;
    logic               chain_q;
    logic               issue;
    bus_op_e            op_sel;
    bus_op_e            op_out;
    logic [7:0]         byte_sel;
    logic [7:0]         ctrl_byte;
    logic [15:0]        addr_ext;
    logic               rsp_fire;
    logic               poll_clr;
    logic               poll_nack;
    logic               poll_out;

    // Next-burst length from address and remaining count
    wpoll_burst_calc #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_calc (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_addr (cur_addr),
        .remaining(remaining),
        .burst_len(burst_len)
    );

    // Per-burst poll budget
    wpoll_poll_ctr #(
        .RETRY_W(RETRY_W)
    ) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (poll_clr),
        .nack     (poll_nack),
        .limit    (limit_q),
        .exhausted(poll_out)
    );

    // Command pulse and response tracking
    wpoll_cmd_port u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .op_in    (op_sel),
        .byte_in  (byte_sel),
        .rsp_valid(eng_rsp_valid),
        .cmd_valid(eng_cmd_valid),
        .cmd_op   (op_out),
        .cmd_byte (eng_cmd_byte),
        .rsp_fire (rsp_fire)
    );

    assign eng_cmd_op = op_out;
    assign addr_ext   = {{(16 - ADDR_W){1'b0}}, cur_addr};
    assign ctrl_byte  = {CTRL_CODE, sel_q, 1'b0};
    assign poll_clr   = rsp_fire && (state == S_WSTOP);
    assign poll_nack  = rsp_fire && (state == S_PCTRL) && !eng_rsp_ack;
    assign src_ready  = (state == S_FETCH);
    assign busy       = (state != S_IDLE);
    assign done       = (state == S_DONE);
    assign err_code   = err_q;

    // Command selection for the current state
    always_comb begin
        issue    = 1'b1;
        op_sel   = BUS_SEND;
        byte_sel = 8'h00;
        case (state)
            S_HSTART, S_PSTART:        op_sel = BUS_START;
            S_HCTRL, S_PCTRL:          byte_sel = ctrl_byte;
            S_HADDR_HI:                byte_sel = {1'b0, addr_ext[14:8]};
            S_HADDR_LO:                byte_sel = addr_ext[7:0];
            S_DATA:                    byte_sel = data_q;
            S_WSTOP, S_PSTOP, S_ABORT: op_sel = BUS_STOP;
            default: begin
                issue  = 1'b0;
                op_sel = BUS_NONE;
            end
        endcase
    end

    // Sequencer state, counters and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            err_q      <= ERR_NONE;
            cur_addr   <= '0;
            remaining  <= '0;
            burst_left <= '0;
            data_q     <= '0;
            sel_q      <= '0;
            limit_q    <= '0;
            chain_q    <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        err_q     <= ERR_NONE;
                        cur_addr  <= start_addr;
                        remaining <= xfer_len;
                        sel_q     <= chip_sel;
                        limit_q   <= poll_limit;
                        chain_q   <= chain_en;
                        state     <= (xfer_len == '0) ? S_DONE : S_HSTART;
                    end
                end
                S_FETCH: begin
                    if (src_valid) begin
                        data_q <= src_data;
                        state  <= S_DATA;
                    end
                end
                S_DONE: state <= S_IDLE;
                default: begin
                    if (rsp_fire) begin
                        case (state)
                            S_HSTART: state <= S_HCTRL;
                            S_HCTRL: begin
                                if (eng_rsp_ack) begin
                                    state <= S_HADDR_HI;
                                end else begin
                                    err_q <= ERR_NACK;
                                    state <= S_ABORT;
                                end
                            end
                            S_HADDR_HI: begin
                                burst_left <= burst_len;
                                if (eng_rsp_ack) begin
                                    state <= S_HADDR_LO;
                                end else begin
                                    err_q <= ERR_NACK;
                                    state <= S_ABORT;
                                end
                            end
                            S_HADDR_LO: begin
                                if (eng_rsp_ack) begin
                                    state <= S_FETCH;
                                end else begin
                                    err_q <= ERR_NACK;
                                    state <= S_ABORT;
                                end
                            end
                            S_DATA: begin
                                if (eng_rsp_ack) begin
                                    cur_addr   <= cur_addr + ADDR_W'(1);
                                    remaining  <= remaining - LEN_W'(1);
                                    burst_left <= burst_left - (PAGE_W + 1)'(1);
                                    state      <= (burst_left == (PAGE_W + 1)'(1)) ? S_WSTOP : S_FETCH;
                                end else begin
                                    err_q <= ERR_NACK;
                                    state <= S_ABORT;
                                end
                            end
                            S_WSTOP:  state <= S_PSTART;
                            S_PSTART: state <= S_PCTRL;
                            S_PCTRL: begin
                                if (eng_rsp_ack) begin
                                    if (remaining == '0) begin
                                        state <= S_PSTOP;
                                    end else if (chain_q) begin
                                        state <= S_HADDR_HI;
                                    end else begin
                                        state <= S_PSTOP;
                                    end
                                end else if (poll_out) begin
                                    err_q <= ERR_POLL;
                                    state <= S_ABORT;
                                end else begin
                                    state <= S_PSTART;
                                end
                            end
                            S_PSTOP:  state <= (remaining == '0) ? S_DONE : S_HSTART;
                            S_ABORT:  state <= S_DONE;
                            default:  state <= S_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    // An accepted source byte goes out as the next command
    assert_fetch_then_send_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready && src_valid) |=> (eng_cmd_valid && (eng_cmd_op == BUS_SEND)
                                      && (eng_cmd_byte == $past(src_data))));

    // Once a byte NACK is recorded, the only command left is a stop
    assert_nack_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_cmd_valid && (err_q == ERR_NACK)) |-> (eng_cmd_op == BUS_STOP));

    // Poll timeout is closed by a stop
    assert_poll_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_cmd_valid && (err_q == ERR_POLL)) |-> (eng_cmd_op == BUS_STOP));

    // Completion is a single-cycle pulse that returns to idle
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

// File: tb/wpoll_seq_tb.sv
`timescale 1ns/1ps
module wpoll_seq_tb;

    localparam int ADDR_W = 15;
    localparam int LEN_W = 16;
    localparam int RETRY_W = 8;
    localparam int PAGE = 64;
    localparam logic [1:0] OP_ST = 2'b01;
    localparam logic [1:0] OP_SP = 2'b10;
    localparam logic [1:0] OP_SD = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic [2:0] chip_sel = '0;
    logic [RETRY_W-1:0] poll_limit = '0;
    logic chain_en = 1'b0;
    logic [7:0] src_data;
    logic src_valid = 1'b0;
    logic src_ready;
    logic eng_cmd_valid;
    logic [1:0] eng_cmd_op;
    logic [7:0] eng_cmd_byte;
    logic eng_rsp_valid = 1'b0;
    logic eng_rsp_ack = 1'b0;
    logic busy, done;
    logic [1:0] err_code;

    always #2.5 clk = ~clk;

    wpoll_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE), .RETRY_W(RETRY_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .xfer_len(xfer_len), .chip_sel(chip_sel), .poll_limit(poll_limit),
        .chain_en(chain_en), .src_data(src_data), .src_valid(src_valid),
        .src_ready(src_ready), .eng_cmd_valid(eng_cmd_valid), .eng_cmd_op(eng_cmd_op),
        .eng_cmd_byte(eng_cmd_byte), .eng_rsp_valid(eng_rsp_valid),
        .eng_rsp_ack(eng_rsp_ack), .busy(busy), .done(done), .err_code(err_code)
    );

    int checks = 0;
    int fails = 0;

    logic [9:0] log_q [0:1023];
    int log_n;
    logic [9:0] exp_q [0:1023];
    int exp_n, exp_err, exp_cons;
    logic [7:0] buf_q [0:255];
    int src_idx = 0;
    int src_base;

    // Engine model state
    bit eng_out, eng_ack_pend, poll_phase, prev_poll, prev_acked;
    logic [1:0] prev_op;
    int eng_lat, poll_left, send_idx, overlap;
    int cfg_busy, cfg_nack;

    assign src_data = buf_q[8'(src_idx - src_base)];

    // Source consumption counter
    always @(posedge clk) begin
        if (src_ready && src_valid) src_idx <= src_idx + 1;
    end

    // Source availability with random gaps
    initial begin
        forever begin
            @(negedge clk);
            src_valid = ($urandom % 4) != 0;
        end
    end

    // Byte engine model: logs commands, answers after a random latency
    initial begin
        forever begin
            @(negedge clk);
            if (eng_rsp_valid) eng_rsp_valid = 1'b0;
            if (eng_out) begin
                if (eng_lat == 0) begin
                    eng_rsp_valid = 1'b1;
                    eng_rsp_ack = eng_ack_pend;
                    eng_out = 1'b0;
                end else begin
                    eng_lat--;
                end
            end
            if (eng_cmd_valid) begin
                if (eng_out) overlap++;
                if (log_n < 1024) log_q[log_n] = {eng_cmd_op, eng_cmd_byte};
                log_n++;
                eng_ack_pend = 1'b1;
                if (eng_cmd_op == OP_SD) begin
                    if (prev_op == OP_ST && poll_phase) begin
                        prev_poll = 1'b1;
                        if (poll_left > 0) begin
                            poll_left--;
                            eng_ack_pend = 1'b0;
                        end else begin
                            poll_phase = 1'b0;
                        end
                    end else begin
                        prev_poll = 1'b0;
                        eng_ack_pend = (send_idx != cfg_nack);
                        send_idx++;
                    end
                    prev_acked = eng_ack_pend;
                end else if (eng_cmd_op == OP_SP) begin
                    if (prev_op == OP_SD && prev_acked && !prev_poll) begin
                        poll_phase = 1'b1;
                        poll_left = cfg_busy;
                    end
                end
                prev_op = eng_cmd_op;
                eng_out = 1'b1;
                eng_lat = $urandom % 3;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] op, input logic [7:0] b);
        exp_q[exp_n] = {op, b};
        exp_n++;
    endtask

    // Expected command stream computed from the requirements
    task automatic build_exp(input int addr, input int len, input logic [2:0] sel,
                             input int limit, input bit chain, input int nbusy, input int nack_at);
        int a, rem, di, sidx, tries, blen;
        bit full;
        logic [7:0] ctrl;
        a = addr; rem = len; di = 0; sidx = 0; full = 1'b1;
        ctrl = {4'b1010, sel, 1'b0};
        exp_n = 0; exp_err = 0; exp_cons = 0;
        if (len == 0) return;
        while (rem > 0) begin
            if (full) begin
                push(OP_ST, 8'h00);
                push(OP_SD, ctrl);
                if (sidx == nack_at) begin push(OP_SP, 8'h00); exp_err = 1; return; end
                sidx++;
            end
            push(OP_SD, {1'b0, 7'(a >> 8)});
            if (sidx == nack_at) begin push(OP_SP, 8'h00); exp_err = 1; return; end
            sidx++;
            push(OP_SD, 8'(a));
            if (sidx == nack_at) begin push(OP_SP, 8'h00); exp_err = 1; return; end
            sidx++;
            blen = PAGE - (a % PAGE);
            if (rem < blen) blen = rem;
            for (int i = 0; i < blen; i++) begin
                push(OP_SD, buf_q[di]);
                di++; exp_cons++;
                if (sidx == nack_at) begin push(OP_SP, 8'h00); exp_err = 1; return; end
                sidx++;
                a = (a + 1) & 32'h7FFF;
                rem--;
            end
            push(OP_SP, 8'h00);
            tries = 0;
            forever begin
                push(OP_ST, 8'h00);
                push(OP_SD, ctrl);
                if (tries < nbusy) begin
                    tries++;
                    if (tries > limit) begin push(OP_SP, 8'h00); exp_err = 2; return; end
                end else begin
                    break;
                end
            end
            if (rem == 0) begin push(OP_SP, 8'h00); break; end
            if (chain) full = 1'b0;
            else begin push(OP_SP, 8'h00); full = 1'b1; end
        end
    endtask

    task automatic run_case(input string req, input int addr, input int len, input logic [2:0] sel,
                            input int limit, input bit chain, input int nbusy, input int nack_at,
                            input bit restart);
        int cyc, mism;
        for (int i = 0; i < 256; i++) buf_q[i] = 8'($urandom);
        eng_out = 0; poll_phase = 0; prev_poll = 0; prev_acked = 0; prev_op = 2'b00;
        poll_left = 0; send_idx = 0; overlap = 0; log_n = 0;
        cfg_busy = nbusy; cfg_nack = nack_at;
        build_exp(addr, len, sel, limit, chain, nbusy, nack_at);
        @(negedge clk);
        src_base = src_idx;
        start_addr = ADDR_W'(addr); xfer_len = LEN_W'(len); chip_sel = sel;
        poll_limit = RETRY_W'(limit); chain_en = chain; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            if (restart && cyc == 12) begin
                start = 1'b1; start_addr = ADDR_W'(addr + 7); xfer_len = LEN_W'(len + 3);
                chain_en = !chain; chip_sel = ~sel;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done == 1'b1, req, "transfer completes", cyc, 0);
        chk(int'(err_code) == exp_err, req, "err_code", int'(err_code), exp_err);
        mism = -1;
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            if (log_q[i] !== exp_q[i] && mism < 0) mism = i;
        end
        chk(log_n == exp_n, req, "command count", log_n, exp_n);
        if (mism >= 0) chk(1'b0, req, "command value", int'(log_q[mism]), int'(exp_q[mism]));
        else chk(1'b1, req, "command value", 0, 0);
        chk((src_idx - src_base) == exp_cons, "R10", "bytes taken", src_idx - src_base, exp_cons);
        chk(overlap == 0, "R12", "overlapping commands", overlap, 0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, req, "returns idle", int'(busy), 0);
    endtask

    // Watchdog
    initial begin
        #(5.0 * 190000);
        fails++;
        $display("FAIL R12 watchdog expired: actual 1 expected 0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && done == 0 && eng_cmd_valid == 0 && src_ready == 0 && err_code == 0,
            "R1", "reset outputs", int'({busy, done, eng_cmd_valid, src_ready, err_code}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 0 && eng_cmd_valid == 0, "R1", "idle after reset", int'(busy), 0);

        run_case("R2", 16'h0010, 5, 3'b101, 4, 0, 2, -1, 0);       // single burst, polls
        run_case("R3", 16'h003E, 6, 3'b010, 4, 0, 1, -1, 0);       // page split 2 + 4
        run_case("R6", 16'h003E, 6, 3'b010, 4, 1, 1, -1, 0);       // chained split
        run_case("R3", 16'h7FFE, 4, 3'b000, 2, 0, 0, -1, 0);      // address wrap
        run_case("R9", 16'h0123, 0, 3'b111, 2, 0, 0, -1, 0);      // empty transfer
        run_case("R7", 16'h0200, 3, 3'b001, 3, 0, 5, -1, 0);      // poll timeout
        run_case("R7", 16'h0200, 3, 3'b001, 0, 0, 1, -1, 0);      // zero budget
        run_case("R4", 16'h0200, 3, 3'b001, 3, 0, 3, -1, 0);      // exactly at budget
        run_case("R8", 16'h0400, 8, 3'b011, 3, 0, 0, 2, 0);       // NACK on low address
        run_case("R8", 16'h0400, 8, 3'b011, 3, 0, 0, 5, 0);       // NACK on a data byte
        run_case("R8", 16'h0400, 8, 3'b011, 3, 0, 0, 0, 0);       // NACK on control byte
        run_case("R5", 16'h0005, 130, 3'b100, 5, 0, 2, -1, 0);    // three bursts
        run_case("R6", 16'h0005, 130, 3'b100, 5, 1, 2, -1, 0);    // three chained bursts
        run_case("R11", 16'h0030, 40, 3'b110, 4, 0, 1, -1, 1);    // restart ignored
        for (int k = 0; k < 8; k++) begin
            run_case("R3", int'($urandom & 32'h7FFF), 1 + int'($urandom % 150),
                     3'($urandom), 3 + int'($urandom % 4), 1'($urandom), int'($urandom % 4), -1, 0);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule